// File: doc/BRIEF.md
# Dual-Mode AES Column Mixer

This unit performs the AES column-mixing step on a complete 128-bit state in one clock cycle, in either the forward direction (encryption) or the inverse direction (decryption). The state is split into four 32-bit columns. Each column is mixed by its own copy of the same column logic. The byte products inside that logic come from a constant multiplier built only from xtime steps and XORs.

A bypass input copies the state to the output unchanged. This serves rounds that skip mixing, such as the last cipher round. The result is captured in an output register when the input valid strobe is high, and the output valid strobe is a one-cycle-delayed copy of the input strobe. S-box substitution, row shifting and key addition belong to neighbouring blocks.

Top module: `mixcol_duo`

## Requirements
- R1: With `inv_mode`=0 and `skip`=0, each column (a0..a3) becomes b_r = {02}·a_r ^ {03}·a_(r+1) ^ a_(r+2) ^ a_(r+3) (indices mod 4). Arithmetic is in GF(2^8) with the reduction polynomial x^8+x^4+x^3+x+1. Example: column db 13 53 45 maps to 8e 4d a1 bc.
- R2: With `inv_mode`=1 and `skip`=0, each column becomes b_r = {0e}·a_r ^ {0b}·a_(r+1) ^ {0d}·a_(r+2) ^ {09}·a_(r+3).
- R3: Applying the inverse mode to the result of the forward mode returns the original state.
- R4: The state is column-major. Byte k = 4c+r (row r, column c) sits at bits [127-8k -: 8], so byte 0 is the most significant byte. Each column is mixed independently of the other columns.
- R5: With `skip`=1, the output equals the input state, whatever the value of `inv_mode`.
- R6: `st_out` is loaded only on a clock edge where `in_vld`=1. Otherwise it keeps its value.
- R7: `out_vld` equals `in_vld` delayed by one clock.
- R8: While `rst_n`=0, `st_out` is all zeros and `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input state is valid; enables the output load |
| inv_mode | input | 1 | 0 = forward mixing, 1 = inverse mixing |
| skip | input | 1 | 1 = pass the state through unmixed |
| st_in | input | 128 | Input state, column-major, byte 0 in the MSB |
| out_vld | output | 1 | Output state is valid |
| st_out | output | 128 | Registered output state |

## Verification
Every result appears exactly one clock edge after the inputs are presented. `st_out` and `out_vld` are registered once, with no other stage in between. The bench sets the inputs after a falling edge and samples the outputs at the next falling edge, which lies after the single rising edge that loads them. The hold check lowers `in_vld` for one cycle with new data on `st_in` and confirms one edge later that `st_out` did not change. The round-trip check sends the forward result back in with inverse mode and compares it to the original state.

// File: rtl/mixcol_duo.sv
module mixcol_duo #(
  parameter int COLS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic               inv_mode,
  input  logic               skip,
  input  logic [32*COLS-1:0] st_in,
  output logic               out_vld,
  output logic [32*COLS-1:0] st_out
);
  localparam int W = 32 * COLS;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  logic [W-1:0] mixed;

  genvar c;
  generate
    for (c = 0; c < COLS; c++) begin : g_col
      logic [7:0] a   [4];
      logic [7:0] x1  [4];
      logic [7:0] x2  [4];
      logic [7:0] x3  [4];
      logic [7:0] m2  [4];
      logic [7:0] m3  [4];
      logic [7:0] m9  [4];
      logic [7:0] m11 [4];
      logic [7:0] m13 [4];
      logic [7:0] m14 [4];
      logic [7:0] b   [4];
      for (genvar r = 0; r < 4; r++) begin : g_row
        assign a[r]   = st_in[W-1-8*(4*c+r) -: 8];
        assign x1[r]  = xt(a[r]);
        assign x2[r]  = xt(x1[r]);
        assign x3[r]  = xt(x2[r]);
        assign m2[r]  = x1[r];
        assign m3[r]  = x1[r] ^ a[r];
        assign m9[r]  = x3[r] ^ a[r];
        assign m11[r] = x3[r] ^ x1[r] ^ a[r];
        assign m13[r] = x3[r] ^ x2[r] ^ a[r];
        assign m14[r] = x3[r] ^ x2[r] ^ x1[r];
      end
      for (genvar r = 0; r < 4; r++) begin : g_out
        assign b[r] = inv_mode
          ? (m14[r] ^ m11[(r+1)%4] ^ m13[(r+2)%4] ^ m9[(r+3)%4])
          : (m2[r]  ^ m3[(r+1)%4]  ^ a[(r+2)%4]   ^ a[(r+3)%4]);
        assign mixed[W-1-8*(4*c+r) -: 8] = b[r];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      st_out  <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) st_out <= skip ? st_in : mixed;
    end
  end
endmodule

module mixcol_duo_chk #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_vld,
  input logic         skip,
  input logic [W-1:0] st_in,
  input logic         out_vld,
  input logic [W-1:0] st_out
);
  // R7
  vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(in_vld));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(st_out));
  // R5
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && skip) |=> st_out == $past(st_in));
  // R8
  always_ff @(posedge clk)
    if (!rst_n) reset_chk: assert (st_out == '0 && !out_vld);
endmodule

bind mixcol_duo mixcol_duo_chk #(.W(32*COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .skip(skip),
  .st_in(st_in), .out_vld(out_vld), .st_out(st_out));

// File: tb/mixcol_duo_tb.sv
module mixcol_duo_tb;
  logic clk = 0, rst_n = 0, in_vld = 0, inv_mode = 0, skip = 0;
  logic [127:0] st_in = '0;
  logic out_vld;
  logic [127:0] st_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mixcol_duo u_dut (.clk, .rst_n, .in_vld, .inv_mode, .skip, .st_in, .out_vld, .st_out);

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] k);
    logic [7:0] p = 0;
    for (int i = 0; i < 8; i++) begin
      if (k[i]) p ^= a;
      a = {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [127:0] ref_mix(input logic [127:0] s, input logic inv);
    logic [127:0] o;
    logic [7:0] k [4];
    if (inv) k = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
    else     k = '{8'h02, 8'h03, 8'h01, 8'h01};
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        logic [7:0] v = 0;
        for (int j = 0; j < 4; j++)
          v ^= gmul(s[127-8*(4*c+(r+j)%4) -: 8], k[j]);
        o[127-8*(4*c+r) -: 8] = v;
      end
    return o;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic inv, input logic sk, input logic [127:0] d);
    in_vld = v; inv_mode = inv; skip = sk; st_in = d;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] d, f, held;
    void'($urandom(32'h5eed));
    @(negedge clk); @(negedge clk);
    chk("R8 reset st_out", st_out, '0);
    chk("R8 reset out_vld", {127'b0, out_vld}, 128'd0);
    rst_n = 1;
    d = {32'hdb135345, 32'hf20a225c, 32'h01010101, 32'hc6c6c6c6};
    drive(1, 0, 0, d);
    chk("R1 known column", st_out[127:96], 32'h8e4da1bc);
    chk("R4 column order", st_out, {32'h8e4da1bc, 32'h9fdc589d, 32'h01010101, 32'hc6c6c6c6});
    chk("R7 out_vld high", {127'b0, out_vld}, 128'd1);
    drive(1, 1, 0, st_out);
    chk("R2 R3 inverse of known", st_out, d);
    drive(1, 1, 1, d);
    chk("R5 bypass inv", st_out, d);
    drive(1, 0, 1, ~d);
    chk("R5 bypass fwd", st_out, ~d);
    held = st_out;
    drive(0, 0, 0, 128'h1234);
    chk("R6 hold", st_out, held);
    chk("R7 out_vld low", {127'b0, out_vld}, 128'd0);
    d = 128'hff << 120;
    drive(1, 0, 0, d);
    chk("R4 single byte isolation", st_out, ref_mix(d, 0));
    for (int i = 0; i < 40; i++) begin
      d = {$urandom, $urandom, $urandom, $urandom};
      drive(1, 0, 0, d);
      f = st_out;
      chk("R1 random fwd", f, ref_mix(d, 0));
      drive(1, 1, 0, f);
      chk("R3 round trip", st_out, d);
      drive(1, 1, 0, d);
      chk("R2 random inv", st_out, ref_mix(d, 1));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule